// File: doc/BRIEF.md
# Vector Element Loop Sequencer

This block sits beside the instruction fetch stage of a core that runs vector instructions one element at a time. When an element operation completes, it decides what happens next. One outcome is to run the same instruction again with the next element position, which it does by pinning the next fetch address to the current one. The other is to let the program counter move on to the following instruction. It keeps a source element index, a destination element index, the active vector length and a vertical-first mode flag.

Each completed element is reported by a one-cycle `stepDone` strobe, together with flags that describe the instruction:
- whether its output is a vector;
- whether its input is a vector;
- whether it uses twin predication;
- whether it is an explicit vertical step;
- whether it is a vector branch that asked to end the loop.

Predicate skipping, decoding and branch-target arithmetic are handled elsewhere. The branch target arrives as an input.

Top module: `vloop_seq`

## Requirements
- R1: Synchronous reset (`rst` high at a clock edge) clears both indices, the vector length and the vertical-first flag. While no strobe is present, `holdPc` and `advancePc` are low.
- R2: `cfgLoad` at a clock edge loads the vector length from `cfgVecLen` and the mode flag from `cfgVertFirst`, and clears both indices. Reset takes priority over `cfgLoad`, and `cfgLoad` takes priority over `stepDone`.
- R3: With the vertical-first flag set and `vfStep` low, a strobe raises `advancePc` and leaves both indices unchanged. This case has top priority among the strobe outcomes.
- R4: A strobe with `isBranch` and `branchEnd` both high, when R3 does not apply, clears both indices. It drives `nextPc` to `branchNia` and keeps both `holdPc` and `advancePc` low.
- R5: An instruction counts as vector as follows. When `twinPred` is high, it counts if `vecIn` or `vecOut` is high. When `twinPred` is low, it counts only if `vecOut` is high.
- R6: A strobe on a vector instruction increments both indices by one, provided that neither index equals the vector length minus one and that R3 and R4 do not apply. It also raises `holdPc`, keeps `advancePc` low, and drives `nextPc` equal to `curPc`.
- R7: In every other strobe case, both indices clear and `advancePc` rises.
- R8: Whenever neither the hold case nor the branch case applies, `nextPc` is `curPc` plus 8 if `prefixed` is high and `curPc` plus 4 otherwise. This includes cycles with no strobe.
- R9: Without `stepDone` or `cfgLoad`, the indices and the vector length keep their values, and `holdPc` and `advancePc` stay low.
- R10: `holdPc` and `advancePc` are never high in the same cycle.
- R11: Indices and the vector length are 7 bits wide, and "length minus one" wraps modulo 128. A length of 0 therefore compares against 127.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfgLoad | input | 1 | Load vector length and mode flag, clear indices |
| cfgVecLen | input | 7 | Vector length to load |
| cfgVertFirst | input | 1 | Vertical-first flag to load |
| stepDone | input | 1 | One element operation has completed |
| vecOut | input | 1 | Instruction output is a vector |
| vecIn | input | 1 | Instruction input is a vector |
| twinPred | input | 1 | Instruction uses twin predication |
| vfStep | input | 1 | Instruction is an explicit vertical step |
| isBranch | input | 1 | Instruction is a vector branch |
| branchEnd | input | 1 | Branch requested loop end |
| prefixed | input | 1 | Instruction is 8 bytes long rather than 4 |
| curPc | input | 32 | Address of the current instruction |
| branchNia | input | 32 | Next address chosen by the branch |
| srcIdx | output | 7 | Source element index |
| dstIdx | output | 7 | Destination element index |
| holdPc | output | 1 | Repeat the current instruction |
| advancePc | output | 1 | Normal program counter advance |
| nextPc | output | 32 | Next fetch address |

## Verification
The bench builds the block with the default 7-bit index width and a 32-bit address width. With 7-bit indices, a vector length of 0 really wraps to 127, so the wrap case in R11 is exercised. Random vector lengths are drawn from 1 to 6, which makes loop completion and branch exits frequent across the random run. Directed cases cover a full four-element loop, the vertical-first bypass with and without `vfStep`, and the zero-length wrap.

// File: rtl/vloop_pkg.sv
package vloop_pkg;
  typedef struct packed {
    logic incIdx;
    logic clrIdx;
    logic holdPc;
    logic advPc;
    logic redirect;
  } stepCtl_t;
endpackage

// File: rtl/vloop_ctrl.sv
module vloop_ctrl
  import vloop_pkg::*;
#(
  parameter int IDX_W = 7
) (
  input  logic             stepDone,
  input  logic             vecOut,
  input  logic             vecIn,
  input  logic             twinPred,
  input  logic             vfStep,
  input  logic             isBranch,
  input  logic             branchEnd,
  input  logic [IDX_W-1:0] srcIdx,
  input  logic [IDX_W-1:0] dstIdx,
  input  logic [IDX_W-1:0] vecLen,
  input  logic             vertFirst,
  output stepCtl_t         ctl
);
  localparam logic [IDX_W-1:0] ONE = {{(IDX_W-1){1'b0}}, 1'b1};

  logic [IDX_W-1:0] lastIdx;
  logic isVec;
  logic vfBypass;
  logic brExit;
  logic canStep;

  always_comb begin
    lastIdx  = vecLen - ONE;
    isVec    = twinPred ? (vecOut | vecIn) : vecOut;
    vfBypass = vertFirst & ~vfStep;
    brExit   = isBranch & branchEnd;
    canStep  = isVec & (srcIdx != lastIdx) & (dstIdx != lastIdx);
  end

  always_comb begin
    ctl = '0;
    if (stepDone) begin
      if (vfBypass) begin
        ctl.advPc = 1'b1;
      end else if (brExit) begin
        ctl.clrIdx   = 1'b1;
        ctl.redirect = 1'b1;
      end else if (canStep) begin
        ctl.incIdx = 1'b1;
        ctl.holdPc = 1'b1;
      end else begin
        ctl.clrIdx = 1'b1;
        ctl.advPc  = 1'b1;
      end
    end
  end
endmodule

// File: rtl/vloop_dp.sv
module vloop_dp
  import vloop_pkg::*;
#(
  parameter int IDX_W        = 7,
  parameter int PC_W         = 64,
  parameter int PLAIN_BYTES  = 4,
  parameter int PREFIX_BYTES = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfgLoad,
  input  logic [IDX_W-1:0] cfgVecLen,
  input  logic             cfgVertFirst,
  input  stepCtl_t         ctl,
  input  logic             prefixed,
  input  logic [PC_W-1:0]  curPc,
  input  logic [PC_W-1:0]  branchNia,
  output logic [IDX_W-1:0] srcIdx,
  output logic [IDX_W-1:0] dstIdx,
  output logic [IDX_W-1:0] vecLen,
  output logic             vertFirst,
  output logic [PC_W-1:0]  nextPc
);
  localparam int LANES = 2;
  localparam logic [PC_W-1:0] PLAIN_INC  = PC_W'(PLAIN_BYTES);
  localparam logic [PC_W-1:0] PREFIX_INC = PC_W'(PREFIX_BYTES);
  localparam logic [IDX_W-1:0] ONE = {{(IDX_W-1){1'b0}}, 1'b1};

  logic [LANES-1:0][IDX_W-1:0] idxQ;

  for (genvar lane = 0; lane < LANES; lane++) begin : gLane
    always_ff @(posedge clk) begin
      if (rst || cfgLoad || ctl.clrIdx) idxQ[lane] <= '0;
      else if (ctl.incIdx)              idxQ[lane] <= idxQ[lane] + ONE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vecLen    <= '0;
      vertFirst <= 1'b0;
    end else if (cfgLoad) begin
      vecLen    <= cfgVecLen;
      vertFirst <= cfgVertFirst;
    end
  end

  assign srcIdx = idxQ[0];
  assign dstIdx = idxQ[1];

  always_comb begin
    if (ctl.redirect)    nextPc = branchNia;
    else if (ctl.holdPc) nextPc = curPc;
    else                 nextPc = curPc + (prefixed ? PREFIX_INC : PLAIN_INC);
  end
endmodule

// File: rtl/vloop_seq.sv
module vloop_seq
  import vloop_pkg::*;
#(
  parameter int IDX_W = 7,
  parameter int PC_W  = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfgLoad,
  input  logic [IDX_W-1:0] cfgVecLen,
  input  logic             cfgVertFirst,
  input  logic             stepDone,
  input  logic             vecOut,
  input  logic             vecIn,
  input  logic             twinPred,
  input  logic             vfStep,
  input  logic             isBranch,
  input  logic             branchEnd,
  input  logic             prefixed,
  input  logic [PC_W-1:0]  curPc,
  input  logic [PC_W-1:0]  branchNia,
  output logic [IDX_W-1:0] srcIdx,
  output logic [IDX_W-1:0] dstIdx,
  output logic             holdPc,
  output logic             advancePc,
  output logic [PC_W-1:0]  nextPc
);
  stepCtl_t         ctl;
  logic [IDX_W-1:0] vecLen;
  logic             vertFirst;
  logic             stepGo;

  // cfgLoad outranks a step in the same cycle
  assign stepGo = stepDone & ~cfgLoad & ~rst;

  vloop_ctrl #(.IDX_W(IDX_W)) uCtrl (
    .stepDone (stepGo),
    .vecOut   (vecOut),
    .vecIn    (vecIn),
    .twinPred (twinPred),
    .vfStep   (vfStep),
    .isBranch (isBranch),
    .branchEnd(branchEnd),
    .srcIdx   (srcIdx),
    .dstIdx   (dstIdx),
    .vecLen   (vecLen),
    .vertFirst(vertFirst),
    .ctl      (ctl)
  );

  vloop_dp #(.IDX_W(IDX_W), .PC_W(PC_W)) uDp (
    .clk         (clk),
    .rst         (rst),
    .cfgLoad     (cfgLoad),
    .cfgVecLen   (cfgVecLen),
    .cfgVertFirst(cfgVertFirst),
    .ctl         (ctl),
    .prefixed    (prefixed),
    .curPc       (curPc),
    .branchNia   (branchNia),
    .srcIdx      (srcIdx),
    .dstIdx      (dstIdx),
    .vecLen      (vecLen),
    .vertFirst   (vertFirst),
    .nextPc      (nextPc)
  );

  assign holdPc    = ctl.holdPc;
  assign advancePc = ctl.advPc;
endmodule

// File: rtl/vloop_seq_chk.sv
module vloop_seq_chk #(
  parameter int IDX_W = 7,
  parameter int PC_W  = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             cfgLoad,
  input logic             stepDone,
  input logic             vfStep,
  input logic             isBranch,
  input logic             branchEnd,
  input logic             prefixed,
  input logic [PC_W-1:0]  curPc,
  input logic [PC_W-1:0]  branchNia,
  input logic [IDX_W-1:0] srcIdx,
  input logic [IDX_W-1:0] dstIdx,
  input logic             holdPc,
  input logic             advancePc,
  input logic [PC_W-1:0]  nextPc,
  input logic             vertFirst
);
  logic seenClk = 1'b0;
  always_ff @(posedge clk) seenClk <= 1'b1;

  a_r10_exclusive: assert property (@(posedge clk) disable iff (rst || !seenClk)
    !(holdPc && advancePc));

  a_r3_vf_keeps_idx: assert property (@(posedge clk) disable iff (rst || !seenClk)
    (stepDone && !cfgLoad && vertFirst && !vfStep) |=> ($stable(srcIdx) && $stable(dstIdx)));

  a_r4_branch_clears: assert property (@(posedge clk) disable iff (rst || !seenClk)
    (stepDone && !cfgLoad && !(vertFirst && !vfStep) && isBranch && branchEnd)
      |-> (nextPc == branchNia && !holdPc && !advancePc));

  a_r6_hold_same_pc: assert property (@(posedge clk) disable iff (rst || !seenClk)
    holdPc |-> (nextPc == curPc));

  a_r6_hold_increments: assert property (@(posedge clk) disable iff (rst || !seenClk)
    (holdPc && !cfgLoad) |=> (srcIdx == $past(srcIdx) + 1'b1));

  a_r8_advance_size: assert property (@(posedge clk) disable iff (rst || !seenClk)
    advancePc |-> (nextPc == curPc + (prefixed ? 32'd8 : 32'd4)));

  a_r9_idle_stable: assert property (@(posedge clk) disable iff (rst || !seenClk)
    (!stepDone && !cfgLoad) |=> ($stable(srcIdx) && $stable(dstIdx)));

  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (rst || !seenClk)
    !stepDone |-> (!holdPc && !advancePc));
endmodule

bind vloop_seq vloop_seq_chk #(.IDX_W(IDX_W), .PC_W(PC_W)) uChk (
  .clk(clk), .rst(rst), .cfgLoad(cfgLoad), .stepDone(stepDone), .vfStep(vfStep),
  .isBranch(isBranch), .branchEnd(branchEnd), .prefixed(prefixed), .curPc(curPc),
  .branchNia(branchNia), .srcIdx(srcIdx), .dstIdx(dstIdx), .holdPc(holdPc),
  .advancePc(advancePc), .nextPc(nextPc), .vertFirst(vertFirst)
);

// File: tb/sim_vloop_seq.sv
module sim_vloop_seq;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst, cfgLoad, cfgVertFirst, stepDone, vecOut, vecIn, twinPred, vfStep;
  logic isBranch, branchEnd, prefixed, holdPc, advancePc;
  logic [6:0] cfgVecLen, srcIdx, dstIdx;
  logic [31:0] curPc, branchNia, nextPc;

  vloop_seq u0 (.*);

  int total = 0, bad = 0, cyc = 0;
  logic [6:0] mIdx, mVl;
  logic mVf;
  logic eHold, eAdv, eClr, eInc, eRedir;

  task automatic finishAll();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      bad++; total++;
      $display("FAIL watchdog: actual=%0d cycles expected<100000", cyc);
      finishAll();
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // reference decision from the requirements
  function automatic void predict();
    logic vec;
    logic [6:0] last;
    eHold = 0; eAdv = 0; eClr = 0; eInc = 0; eRedir = 0;
    vec  = twinPred ? (vecIn | vecOut) : vecOut;
    last = mVl - 7'd1;
    if (stepDone && !cfgLoad) begin
      if (mVf && !vfStep) eAdv = 1;
      else if (isBranch && branchEnd) begin eClr = 1; eRedir = 1; end
      else if (vec && mIdx != last) begin eInc = 1; eHold = 1; end
      else begin eClr = 1; eAdv = 1; end
    end
  endfunction

  // inputs already set; check comb outputs now, then clock, update model, check indices
  task automatic step();
    logic [31:0] expPc;
    predict();
    #3;
    expPc = eRedir ? branchNia : (eHold ? curPc : curPc + (prefixed ? 32'd8 : 32'd4));
    chk("R6/R7 holdPc", {31'd0, holdPc}, {31'd0, eHold});
    chk("R3/R7 advancePc", {31'd0, advancePc}, {31'd0, eAdv});
    chk("R4/R8 nextPc", nextPc, expPc);
    chk("R10 exclusive", {31'd0, holdPc & advancePc}, 32'd0);
    @(posedge clk);
    if (cfgLoad) begin mVl = cfgVecLen; mVf = cfgVertFirst; mIdx = 0; end
    else if (eClr) mIdx = 0;
    else if (eInc) mIdx = mIdx + 7'd1;
    @(negedge clk);
    chk("R2/R6/R9 srcIdx", {25'd0, srcIdx}, {25'd0, mIdx});
    chk("R2/R6/R9 dstIdx", {25'd0, dstIdx}, {25'd0, mIdx});
  endtask

  task automatic idleIn();
    cfgLoad = 0; cfgVecLen = 0; cfgVertFirst = 0; stepDone = 0; vecOut = 0; vecIn = 0;
    twinPred = 0; vfStep = 0; isBranch = 0; branchEnd = 0; prefixed = 0;
    curPc = 32'h1000; branchNia = 32'h2000;
  endtask

  task automatic load(input logic [6:0] vl, input logic vf);
    idleIn(); cfgLoad = 1; cfgVecLen = vl; cfgVertFirst = vf; step();
  endtask

  initial begin
    void'($urandom(32'd1234));
    idleIn(); rst = 1;
    @(negedge clk); @(negedge clk);
    rst = 0; mIdx = 0; mVl = 0; mVf = 0;
    // R1: reset state
    chk("R1 srcIdx", {25'd0, srcIdx}, 0);
    chk("R1 holdPc", {31'd0, holdPc}, 0);
    chk("R1 advancePc", {31'd0, advancePc}, 0);

    // R6/R7: full loop of length 4, vector output
    load(7'd4, 1'b0);
    for (int i = 0; i < 4; i++) begin
      idleIn(); stepDone = 1; vecOut = 1; step();
    end
    // R5: twin predication with only input vector counts as vector
    idleIn(); stepDone = 1; twinPred = 1; vecIn = 1; step();
    // R5: without twin predication input vector alone is scalar -> advance
    idleIn(); stepDone = 1; vecIn = 1; prefixed = 1; step();
    // R4: branch exit mid loop
    idleIn(); stepDone = 1; vecOut = 1; step();
    idleIn(); stepDone = 1; vecOut = 1; isBranch = 1; branchEnd = 1; step();
    // R3: vertical-first bypass keeps indices
    load(7'd5, 1'b1);
    idleIn(); stepDone = 1; vecOut = 1; step();
    idleIn(); stepDone = 1; vecOut = 1; vfStep = 1; step();
    idleIn(); stepDone = 1; vecOut = 1; step();
    // R11: length 0 wraps to 127 as last index
    load(7'd0, 1'b0);
    idleIn(); stepDone = 1; vecOut = 1; step();
    // R9: no strobe
    idleIn(); step();

    // random mix
    for (int n = 0; n < 3000; n++) begin
      idleIn();
      if ($urandom_range(0, 19) == 0) begin
        cfgLoad = 1; cfgVecLen = 7'($urandom_range(1, 6)); cfgVertFirst = ($urandom_range(0, 3) == 0);
      end
      stepDone  = ($urandom_range(0, 3) != 0);
      vecOut    = 1'($urandom); vecIn = 1'($urandom); twinPred = 1'($urandom);
      vfStep    = 1'($urandom); isBranch = ($urandom_range(0, 4) == 0); branchEnd = 1'($urandom);
      prefixed  = 1'($urandom);
      curPc     = $urandom; branchNia = $urandom;
      step();
    end

    // R1: reset mid-run clears everything
    idleIn(); rst = 1; @(negedge clk); rst = 0; mIdx = 0; mVl = 0; mVf = 0;
    chk("R1 reset idx", {25'd0, srcIdx}, 0);
    idleIn(); stepDone = 1; vecOut = 1; step();
    finishAll();
  end
endmodule